// File: doc/BRIEF.md
# Ring Free-Space Monitor with Stall Watchdog

This block watches a circular command ring. A consumer advances a hardware head pointer. The producer owns a tail pointer and a ring-size setting. From these the block works out, every cycle, how many bytes the producer may still write. It always keeps an 8-byte guard gap between the tail and the head, so that a full ring can never look the same as an empty one. The free-space figure and an empty flag are offered as registered outputs.

A producer that needs room raises a one-cycle request. The request carries either a byte count or a drain flag. The drain flag asks for the whole ring less the guard gap, which is only available once the consumer has caught up completely. The block grants the request as soon as the free space covers it. Otherwise it keeps polling once per cycle. While it polls, a stall watchdog counts the polls that found too little room. The count restarts whenever the sampled head moves. A busy timeout is therefore reported only when the consumer has really stopped. The timeout stays up until the next request is accepted.

Top module: `ring_space_monitor`

## Requirements
- R1: `free_o` shows, one clock edge after the inputs are applied, head − (tail + 8) computed on pointers masked with `size_i − 1`, with `size_i` added when the difference is negative. `size_i` is a power of two and at least 16.
- R2: When the difference is still negative after `size_i` has been added (the tail has run into the guard gap), `free_o` reads 0.
- R3: `empty_o` is 1 one edge after the masked head equals the masked tail. In that case `free_o` equals `size_i − 8`.
- R4: A request accepted while idle is checked against the free space on its own edge. If the free space is at least the requested count, `grant_o` is high for exactly one cycle after that edge and `busy_o` stays low.
- R5: A request that does not fit sets `busy_o` after its edge. The block then polls on every edge and raises `grant_o` for one cycle on the first edge at which the free space covers the count. `busy_o` falls on that same edge.
- R6: A request with `req_drain_i = 1` ignores `req_bytes_i` and asks for `size_i − 8` bytes.
- R7: The request edge counts as poll 1. If the head does not change, the edge of failing poll `POLL_LIMIT` raises `timeout_o` and clears `busy_o`. With a fixed head, that is `POLL_LIMIT − 1` edges after the request edge. `POLL_LIMIT` is at least 2.
- R8: A failing poll that sees a masked head different from the previous poll restarts the count at 1.
- R9: `timeout_o` stays high until the next accepted request and clears on that request's edge.
- R10: A request raised while `busy_o` is high is ignored. It neither grants nor changes the pending count.
- R11: `grant_o` and `timeout_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| head_i | input | ADDR_W | Consumer head pointer, byte address |
| tail_i | input | ADDR_W | Producer tail pointer, byte address |
| size_i | input | ADDR_W+1 | Ring size in bytes, power of two |
| req_i | input | 1 | One-cycle space request |
| req_drain_i | input | 1 | Request asks for the whole ring less the guard gap |
| req_bytes_i | input | ADDR_W+1 | Requested byte count |
| free_o | output | ADDR_W+1 | Registered free space in bytes |
| empty_o | output | 1 | Registered ring-empty flag |
| busy_o | output | 1 | A request is waiting for space |
| grant_o | output | 1 | One-cycle grant pulse |
| timeout_o | output | 1 | Sticky stall timeout |

## Verification
`free_o` and `empty_o` are due one edge after the pointers change, and the bench reads them at the falling edge that follows that rising edge. Grants for requests that fit are due on the request edge itself. Grants for waiting requests are due on the first edge at which the new head leaves enough room, so the head is moved at a falling edge and the grant is read at the next falling edge. The timeout is counted edge by edge from the request. The bench confirms it is absent one edge before poll `POLL_LIMIT` and present right after that poll, both with a fixed head and after a head move that restarts the window.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
  typedef enum logic [0:0] {
    RSM_IDLE = 1'b0,
    RSM_WAIT = 1'b1
  } rsm_state_e;
endpackage

// File: rtl/rsm_space_calc.sv
module rsm_space_calc #(
  parameter int ADDR_W = 16,
  parameter int GUARD  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] head_i,
  input  logic [ADDR_W-1:0] tail_i,
  input  logic [ADDR_W:0]   size_i,
  output logic [ADDR_W-1:0] head_m_o,
  output logic [ADDR_W:0]   free_now_o,
  output logic [ADDR_W:0]   free_q_o,
  output logic              empty_q_o
);
  localparam int CW = ADDR_W + 2;

  logic [ADDR_W:0]   size_m1;
  logic [ADDR_W-1:0] wrap_mask;
  logic [ADDR_W-1:0] tail_m;
  logic [CW-1:0]     diff;
  logic [CW-1:0]     wrapped;
  logic [ADDR_W:0]   free_d;
  logic              empty_d;

  always_comb begin
    size_m1   = size_i - 1'b1;
    wrap_mask = size_m1[ADDR_W-1:0];
    head_m_o  = head_i & wrap_mask;
    tail_m    = tail_i & wrap_mask;
    diff      = {2'b00, head_m_o} - {2'b00, tail_m} - CW'(GUARD);
    wrapped   = diff + {1'b0, size_i};
    if (!diff[CW-1]) begin
      free_d = diff[ADDR_W:0];
    end else if (!wrapped[CW-1]) begin
      free_d = wrapped[ADDR_W:0];
    end else begin
      free_d = '0;
    end
    empty_d    = (head_m_o == tail_m);
    free_now_o = free_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q_o  <= '0;
      empty_q_o <= 1'b0;
    end else begin
      free_q_o  <= free_d;
      empty_q_o <= empty_d;
    end
  end
endmodule

// File: rtl/rsm_stall_timer.sv
module rsm_stall_timer #(
  parameter int ADDR_W     = 16,
  parameter int POLL_LIMIT = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              poll_fail_i,
  input  logic [ADDR_W-1:0] head_m_i,
  output logic              expire_o
);
  localparam int CNT_W = $clog2(POLL_LIMIT + 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] last_q, last_d;
  logic              poll_en;

  always_comb begin
    poll_en = start_i | poll_fail_i;
    cnt_d   = cnt_q;
    last_d  = last_q;
    if (start_i) begin
      cnt_d  = CNT_W'(1);
      last_d = head_m_i;
    end else if (poll_fail_i) begin
      cnt_d  = (head_m_i == last_q) ? cnt_q + 1'b1 : CNT_W'(1);
      last_d = head_m_i;
    end
    expire_o = poll_en && (cnt_d >= CNT_W'(POLL_LIMIT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= '0;
    end else if (poll_en) begin
      cnt_q  <= cnt_d;
      last_q <= last_d;
    end
  end
endmodule

// File: rtl/rsm_req_ctrl.sv
module rsm_req_ctrl
  import rsm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int GUARD  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_i,
  input  logic            req_drain_i,
  input  logic [ADDR_W:0] req_bytes_i,
  input  logic [ADDR_W:0] size_i,
  input  logic [ADDR_W:0] free_now_i,
  input  logic            expire_i,
  output logic            start_o,
  output logic            poll_fail_o,
  output logic            busy_o,
  output logic            grant_o,
  output logic            timeout_o
);
  rsm_state_e      state_q, state_d;
  logic [ADDR_W:0] need_q, need_d, need_sel;
  logic            grant_d, timeout_d;

  always_comb begin
    need_sel    = req_drain_i ? (size_i - (ADDR_W+1)'(GUARD)) : req_bytes_i;
    state_d     = state_q;
    need_d      = need_q;
    grant_d     = 1'b0;
    timeout_d   = timeout_o;
    start_o     = 1'b0;
    poll_fail_o = 1'b0;
    unique case (state_q)
      RSM_IDLE: begin
        if (req_i) begin
          timeout_d = 1'b0;
          need_d    = need_sel;
          if (free_now_i >= need_sel) begin
            grant_d = 1'b1;
          end else begin
            start_o = 1'b1;
            if (expire_i) begin
              timeout_d = 1'b1;
            end else begin
              state_d = RSM_WAIT;
            end
          end
        end
      end
      RSM_WAIT: begin
        if (free_now_i >= need_q) begin
          grant_d = 1'b1;
          state_d = RSM_IDLE;
        end else begin
          poll_fail_o = 1'b1;
          if (expire_i) begin
            timeout_d = 1'b1;
            state_d   = RSM_IDLE;
          end
        end
      end
      default: state_d = RSM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RSM_IDLE;
      need_q    <= '0;
      grant_o   <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      need_q    <= need_d;
      grant_o   <= grant_d;
      timeout_o <= timeout_d;
    end
  end

  assign busy_o = (state_q == RSM_WAIT);
endmodule

// File: rtl/ring_space_monitor.sv
module ring_space_monitor #(
  parameter int ADDR_W     = 16,
  parameter int GUARD      = 8,
  parameter int POLL_LIMIT = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] head_i,
  input  logic [ADDR_W-1:0] tail_i,
  input  logic [ADDR_W:0]   size_i,
  input  logic              req_i,
  input  logic              req_drain_i,
  input  logic [ADDR_W:0]   req_bytes_i,
  output logic [ADDR_W:0]   free_o,
  output logic              empty_o,
  output logic              busy_o,
  output logic              grant_o,
  output logic              timeout_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [ADDR_W-1:0] head_m;
  logic [ADDR_W:0]   free_now;
  logic              start, poll_fail, expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rsm_space_calc #(.ADDR_W(ADDR_W), .GUARD(GUARD)) u_space (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .head_i     (head_i),
    .tail_i     (tail_i),
    .size_i     (size_i),
    .head_m_o   (head_m),
    .free_now_o (free_now),
    .free_q_o   (free_o),
    .empty_q_o  (empty_o)
  );

  rsm_stall_timer #(.ADDR_W(ADDR_W), .POLL_LIMIT(POLL_LIMIT)) u_timer (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start_i     (start),
    .poll_fail_i (poll_fail),
    .head_m_i    (head_m),
    .expire_o    (expire)
  );

  rsm_req_ctrl #(.ADDR_W(ADDR_W), .GUARD(GUARD)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req_i       (req_i),
    .req_drain_i (req_drain_i),
    .req_bytes_i (req_bytes_i),
    .size_i      (size_i),
    .free_now_i  (free_now),
    .expire_i    (expire),
    .start_o     (start),
    .poll_fail_o (poll_fail),
    .busy_o      (busy_o),
    .grant_o     (grant_o),
    .timeout_o   (timeout_o)
  );
endmodule

// File: rtl/ring_space_monitor_chk.sv
module ring_space_monitor_chk #(
  parameter int ADDR_W = 16,
  parameter int GUARD  = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [ADDR_W:0] size_i,
  input logic            req_i,
  input logic [ADDR_W:0] free_o,
  input logic            empty_o,
  input logic            busy_o,
  input logic            grant_o,
  input logic            timeout_o
);
  p_free_below_size_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(size_i) != '0) |-> (free_o < $past(size_i)));

  p_empty_full_space_r3: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> (free_o == $past(size_i) - (ADDR_W+1)'(GUARD)));

  p_grant_not_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |-> !busy_o);

  p_timeout_from_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> $past(busy_o));

  p_timeout_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_o && !req_i) |=> timeout_o);

  p_timeout_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !busy_o) |=> !timeout_o);

  p_grant_timeout_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_o && timeout_o));
endmodule

bind ring_space_monitor ring_space_monitor_chk #(.ADDR_W(ADDR_W), .GUARD(GUARD)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .size_i    (size_i),
  .req_i     (req_i),
  .free_o    (free_o),
  .empty_o   (empty_o),
  .busy_o    (busy_o),
  .grant_o   (grant_o),
  .timeout_o (timeout_o)
);

// File: tb/ring_space_monitor_tb_top.sv
module ring_space_monitor_tb_top;
  localparam int AW = 6;
  localparam int PL = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] head, tail;
  logic [AW:0]   size;
  logic          req, drain;
  logic [AW:0]   bytes;
  logic [AW:0]   free_o;
  logic          empty_o, busy_o, grant_o, timeout_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  ring_space_monitor #(.ADDR_W(AW), .GUARD(8), .POLL_LIMIT(PL)) dut_i (
    .clk(clk), .rst_n(rst_n), .head_i(head), .tail_i(tail), .size_i(size),
    .req_i(req), .req_drain_i(drain), .req_bytes_i(bytes),
    .free_o(free_o), .empty_o(empty_o), .busy_o(busy_o),
    .grant_o(grant_o), .timeout_o(timeout_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic request(input int nbytes, input bit dr);
    req = 1'b1; bytes = (AW+1)'(nbytes); drain = dr;
    step();
    req = 1'b0; drain = 1'b0;
  endtask

  function automatic int exp_free(input int h, input int t, input int sz);
    int v;
    v = (h % sz) - ((t % sz) + 8);
    if (v < 0) v += sz;
    if (v < 0) v = 0;
    return v;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int sweep_bad;
    rst_n = 1'b0; head = '0; tail = '0; size = 7'd32;
    req = 1'b0; drain = 1'b0; bytes = '0;
    repeat (3) step();
    chk(free_o == 0 && !grant_o && !timeout_o && !busy_o && !empty_o, "reset", int'(free_o), 0);
    rst_n = 1'b1;
    repeat (4) step();

    // R1 R2 R3: sweep every pointer pair, including upper bits the mask drops
    foreach (size[i]) ; // no-op keeps size in sensitivity of nothing
    for (int s = 0; s < 2; s++) begin
      int sz = (s == 0) ? 32 : 64;
      size = (AW+1)'(sz);
      sweep_bad = 0;
      for (int h = 0; h < 64; h++) begin
        for (int t = 0; t < 64; t++) begin
          int ef;
          head = AW'(h); tail = AW'(t);
          step();
          ef = exp_free(h, t, sz);
          if (int'(free_o) != ef) begin
            sweep_bad++;
            if (sweep_bad < 4) chk(0, (ef == 0) ? "R2 saturate" : "R1 free", int'(free_o), ef);
          end
          if (empty_o != ((h % sz) == (t % sz))) begin
            sweep_bad++;
            if (sweep_bad < 4) chk(0, "R3 empty", int'(empty_o), int'((h % sz) == (t % sz)));
          end
        end
      end
      chk(sweep_bad == 0, "R1 R2 R3 sweep", sweep_bad, 0);
    end
    size = 7'd32;
    head = 6'd0; tail = 6'd31; step();
    chk(free_o == 0, "R2 tail in guard gap", int'(free_o), 0);
    head = 6'd5; tail = 6'd5; step();
    chk(empty_o && free_o == 24, "R3 empty full space", int'(free_o), 24);

    // R4: fits immediately (free 24, ask 24)
    request(24, 0);
    chk(grant_o && !busy_o, "R4 grant on request edge", int'(grant_o), 1);
    step();
    chk(!grant_o, "R4 grant is one cycle", int'(grant_o), 0);

    // R5, R10: waits then grants when head moves
    head = 6'd10; tail = 6'd0; step();           // free 2
    request(20, 0);
    chk(busy_o && !grant_o, "R5 busy while short", int'(busy_o), 1);
    request(1, 0);                                 // would fit, must be ignored
    chk(!grant_o && busy_o, "R10 request ignored while busy", int'(grant_o), 0);
    step();
    chk(busy_o && !grant_o, "R10 pending count unchanged", int'(busy_o), 1);
    head = 6'd28; step();                          // free 20
    chk(grant_o && !busy_o, "R5 grant when space appears", int'(grant_o), 1);
    step();
    chk(!grant_o, "R5 grant pulse ends", int'(grant_o), 0);

    // R7: fixed head, timeout on poll PL
    head = 6'd10; tail = 6'd0; step();           // free 2
    request(5, 0);                                 // poll 1
    repeat (PL - 2) step();                        // polls 2..PL-1
    chk(busy_o && !timeout_o, "R7 no timeout before limit", int'(timeout_o), 0);
    step();                                        // poll PL
    chk(timeout_o && !busy_o && !grant_o, "R7 timeout at limit", int'(timeout_o), 1);

    // R9: held until next request
    repeat (3) step();
    chk(timeout_o, "R9 timeout held", int'(timeout_o), 1);

    // R6 and R9: drain request fits when empty, clears timeout
    head = 6'd3; tail = 6'd3; step();
    request(0, 1);
    chk(grant_o && !timeout_o, "R6 drain grant, R9 clear", int'(grant_o), 1);
    head = 6'd12; step();                          // free 1
    request(0, 1);
    chk(busy_o && !grant_o, "R6 drain waits", int'(busy_o), 1);
    head = 6'd3; step();
    chk(grant_o && !busy_o, "R6 drain granted on drain", int'(grant_o), 1);
    head = 6'd12; step();
    request(1, 1);                                 // drain ignores byte count
    chk(busy_o && !grant_o, "R6 byte count ignored", int'(busy_o), 1);
    head = 6'd3; step();
    step();

    // R8: head move restarts the window
    head = 6'd10; tail = 6'd0; step();
    request(5, 0);                                 // poll 1
    step();                                        // poll 2
    head = 6'd11; step();                          // poll restarts at 1
    repeat (PL - 2) step();
    chk(busy_o && !timeout_o, "R8 window restarted", int'(timeout_o), 0);
    step();
    chk(timeout_o && !busy_o, "R8 timeout after restart", int'(timeout_o), 1);
    chk(!(timeout_o && grant_o), "R11 exclusive", int'(grant_o), 0);

    // R11 after a clearing grant
    head = 6'd3; tail = 6'd3; step();
    request(8, 0);
    chk(grant_o && !timeout_o, "R11 grant without timeout", int'(timeout_o), 0);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule